// File: doc/BRIEF.md
# Four-Lane Alignment-Character Deskew Unit

This unit sits behind four 8b/10b decoders that share one clock. Each lane delivers one decoded byte per cycle with a flag that marks control characters. Cable and serializer paths give the lanes different delays, so a character sent on all four lanes at once can arrive on different cycles. The unit gives each lane a small queue. Each queue drops everything up to its first alignment character (/A/, the control character with byte value 0x7C). Reading of the four queues starts in the same cycle, once every lane holds its /A/. From then on, every /A/ column sent leaves the unit as one output column.

A tracker watches the output columns and keeps the alignment status. The status is declared only after the first all-/A/ column plus three more such columns. It is withdrawn only after four columns in a row in which some lanes, but not all, carry /A/. If the skew is too large for the queues, the unit flushes all four queues, pulses an error and starts looking for /A/ again. A per-lane synchronisation input and the synchronous active-low reset both send the tracker back to the unaligned state.

Top module: `lane_deskew`

## Requirements
- R1: Each lane discards its input until it sees an /A/ (control flag 1, byte 0x7C). That /A/ is the first word the lane ever emits.
- R2: `col_valid` first rises when all four lanes have captured an /A/, and the first valid column is all /A/. After that, lane l of the k-th valid column equals the (k)-th word of lane l counted from its first /A/, with no gap.
- R3: Lane-to-lane skew of up to 15 cycles is absorbed with no error pulse.
- R4: If any lane queue holds 16 words while some lane still lacks its /A/, every queue is flushed, `overflow_err` is high for exactly one cycle, no column is output, and capture starts again.
- R5: A column counts as aligned when it is valid and all four lanes carry /A/. `lanes_aligned` rises in the cycle after the fourth aligned column seen in the unaligned state.
- R6: In the unaligned state, a misaligned column (valid, with /A/ on one to three lanes) resets the aligned-column count to zero.
- R7: In the aligned state, `lanes_aligned` falls in the cycle after the fourth misaligned column in a row.
- R8: In the aligned state, an aligned column clears the misaligned-column count.
- R9: A valid column with no /A/ changes neither count.
- R10: If any bit of `sync_ok` is low in a cycle, `lanes_aligned` is low in the next cycle and both counts restart from zero.
- R11: While `rst_n` is low at a clock edge, all outputs are zero after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for all lanes |
| rst_n | input | 1 | Synchronous reset, active low |
| sync_ok | input | 4 | Per-lane word-synchronisation status, high when the lane is in sync |
| rx_data | input | 32 | Decoded bytes; lane l occupies bits 8l+7:8l |
| rx_ctl | input | 4 | Control-character flag per lane |
| col_data | output | 32 | Deskewed bytes, laid out the same way as rx_data |
| col_ctl | output | 4 | Deskewed control flags |
| col_valid | output | 1 | High while the queues are being read |
| lanes_aligned | output | 1 | Alignment status |
| overflow_err | output | 1 | One-cycle pulse when the queues are flushed because of excess skew |

## Verification
The hardest states to reach are in the tracker after lock. There the misaligned-column count must be cleared by an aligned column before it reaches four, or it must actually reach four. The queues re-align any stream at start, so misaligned columns cannot come from skew alone. The stimulus therefore either shifts one lane by a word partway through a run, or places isolated /A/ bursts on one lane between the regular /A/ columns. Random skews and /A/ spacings, drawn from a seeded generator, are checked against a column-by-column model of the status.

// File: rtl/deskew_pkg.sv
package deskew_pkg;

    localparam int          BYTE_W     = 8;
    localparam logic [7:0]  ALIGN_BYTE = 8'h7C;

    typedef struct packed {
        logic              ctl;
        logic [BYTE_W-1:0] data;
    } lane_word_t;

    typedef enum logic [0:0] {
        TRK_HUNT = 1'b0,
        TRK_LOCK = 1'b1
    } trk_state_t;

    function automatic logic is_align(lane_word_t w);
        return w.ctl && (w.data == ALIGN_BYTE);
    endfunction

endpackage

// File: rtl/deskew_lane_fifo.sv
module deskew_lane_fifo
    import deskew_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flush,
    input  logic       rd_en,
    input  lane_word_t wr_word,
    output logic       captured,
    output logic       full,
    output lane_word_t head
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] wr_ptr;
        logic [PW-1:0] rd_ptr;
        logic [CW-1:0] cnt;
        logic          cap;
    } fifo_st_t;

    fifo_st_t   st_q, st_d;
    logic       we;
    lane_word_t mem [DEPTH];

    function automatic logic [PW-1:0] ptr_inc(logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        we   = 1'b0;
        if (flush) begin
            st_d = '0;
        end else begin
            // once captured, every word is kept; before that only /A/ opens the lane
            we = st_q.cap || is_align(wr_word);
            if (we) begin
                st_d.cap    = 1'b1;
                st_d.wr_ptr = ptr_inc(st_q.wr_ptr);
            end
            if (rd_en) begin
                st_d.rd_ptr = ptr_inc(st_q.rd_ptr);
            end
            st_d.cnt = st_q.cnt + CW'(we) - CW'(rd_en);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (we) begin
            mem[st_q.wr_ptr] <= wr_word;
        end
    end

    assign head     = mem[st_q.rd_ptr];
    assign captured = st_q.cap;
    assign full     = (st_q.cnt == CW'(DEPTH));

endmodule

// File: rtl/deskew_align_tracker.sv
module deskew_align_tracker
    import deskew_pkg::*;
#(
    parameter int LANES     = 4,
    parameter int ACQ_COLS  = 4,
    parameter int LOSS_COLS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             col_valid,
    input  logic [LANES-1:0] col_is_a,
    input  logic             sync_all,
    output logic             aligned
);

    localparam int AW = $clog2(ACQ_COLS + 1);
    localparam int LW = $clog2(LOSS_COLS + 1);

    typedef struct packed {
        trk_state_t    st;
        logic [AW-1:0] acq;
        logic [LW-1:0] miss;
    } trk_t;

    trk_t trk_q, trk_d;
    logic hit_col, skew_col;

    always_comb begin
        hit_col  = col_valid && (&col_is_a);
        skew_col = col_valid && (|col_is_a) && !(&col_is_a);
        trk_d    = trk_q;
        if (!sync_all) begin
            trk_d = '0;
        end else begin
            unique case (trk_q.st)
                TRK_HUNT: begin
                    if (hit_col) begin
                        if (trk_q.acq == AW'(ACQ_COLS - 1)) begin
                            trk_d.st   = TRK_LOCK;
                            trk_d.acq  = '0;
                            trk_d.miss = '0;
                        end else begin
                            trk_d.acq = trk_q.acq + 1'b1;
                        end
                    end else if (skew_col) begin
                        trk_d.acq = '0;
                    end
                end
                TRK_LOCK: begin
                    if (hit_col) begin
                        trk_d.miss = '0;
                    end else if (skew_col) begin
                        if (trk_q.miss == LW'(LOSS_COLS - 1)) begin
                            trk_d = '0;
                        end else begin
                            trk_d.miss = trk_q.miss + 1'b1;
                        end
                    end
                end
                default: trk_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign aligned = (trk_q.st == TRK_LOCK);

endmodule

// File: rtl/lane_deskew.sv
module lane_deskew
    import deskew_pkg::*;
#(
    parameter int LANES     = 4,
    parameter int DEPTH     = 16,
    parameter int ACQ_COLS  = 4,
    parameter int LOSS_COLS = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES-1:0]        sync_ok,
    input  logic [LANES*BYTE_W-1:0] rx_data,
    input  logic [LANES-1:0]        rx_ctl,
    output logic [LANES*BYTE_W-1:0] col_data,
    output logic [LANES-1:0]        col_ctl,
    output logic                    col_valid,
    output logic                    lanes_aligned,
    output logic                    overflow_err
);

    typedef struct packed {
        logic [LANES*BYTE_W-1:0] data;
        logic [LANES-1:0]        ctl;
        logic                    valid;
        logic                    err;
    } col_st_t;

    col_st_t          col_q, col_d;
    logic [LANES-1:0] cap;
    logic [LANES-1:0] full;
    logic [LANES-1:0] out_is_a;
    lane_word_t       heads [LANES];
    logic             reading;
    logic             overflow;

    // read every queue together once each one holds its /A/
    assign reading  = &cap;
    assign overflow = !reading && |(cap & full);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        lane_word_t in_w;
        lane_word_t out_w;
        assign in_w.ctl  = rx_ctl[l];
        assign in_w.data = rx_data[l*BYTE_W +: BYTE_W];

        deskew_lane_fifo #(.DEPTH(DEPTH)) u_fifo (
            .clk      (clk),
            .rst_n    (rst_n),
            .flush    (overflow),
            .rd_en    (reading),
            .wr_word  (in_w),
            .captured (cap[l]),
            .full     (full[l]),
            .head     (heads[l])
        );

        assign out_w.ctl  = col_q.ctl[l];
        assign out_w.data = col_q.data[l*BYTE_W +: BYTE_W];
        assign out_is_a[l] = is_align(out_w);
    end

    always_comb begin
        col_d       = '0;
        col_d.valid = reading;
        col_d.err   = overflow;
        if (reading) begin
            for (int l = 0; l < LANES; l++) begin
                col_d.data[l*BYTE_W +: BYTE_W] = heads[l].data;
                col_d.ctl[l]                   = heads[l].ctl;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q <= '0;
        end else begin
            col_q <= col_d;
        end
    end

    deskew_align_tracker #(
        .LANES     (LANES),
        .ACQ_COLS  (ACQ_COLS),
        .LOSS_COLS (LOSS_COLS)
    ) u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .col_valid (col_q.valid),
        .col_is_a  (out_is_a),
        .sync_all  (&sync_ok),
        .aligned   (lanes_aligned)
    );

    assign col_data     = col_q.data;
    assign col_ctl      = col_q.ctl;
    assign col_valid    = col_q.valid;
    assign overflow_err = col_q.err;

endmodule

// File: rtl/deskew_checks.sv
module deskew_checks #(
    parameter int LANES = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [LANES-1:0]   sync_ok,
    input logic [LANES*8-1:0] col_data,
    input logic [LANES-1:0]   col_ctl,
    input logic               col_valid,
    input logic               lanes_aligned,
    input logic               overflow_err
);

    logic [LANES-1:0] lane_a;
    logic             all_a, some_a;

    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            lane_a[l] = col_ctl[l] && (col_data[l*8 +: 8] == 8'h7C);
        end
        all_a  = &lane_a;
        some_a = |lane_a;
    end

    assert_err_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_err |=> !overflow_err);

    assert_err_no_column_R4: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_err |-> !col_valid);

    assert_first_column_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(col_valid) |-> all_a);

    assert_lock_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lanes_aligned) |-> $past(col_valid && all_a && (&sync_ok)));

    assert_sync_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(&sync_ok) |=> !lanes_aligned);

    assert_loss_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lanes_aligned) |-> $past(!(&sync_ok) || (col_valid && some_a && !all_a)));

endmodule

bind lane_deskew deskew_checks #(.LANES(LANES)) u_checks (
    .clk           (clk),
    .rst_n         (rst_n),
    .sync_ok       (sync_ok),
    .col_data      (col_data),
    .col_ctl       (col_ctl),
    .col_valid     (col_valid),
    .lanes_aligned (lanes_aligned),
    .overflow_err  (overflow_err)
);

// File: tb/tb_lane_deskew.sv
`timescale 1ns/1ps
module tb_lane_deskew;

    localparam int L    = 4;
    localparam int N    = 320;
    localparam int TAIL = 40;
    localparam logic [8:0] AW9 = 9'h17C;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [L-1:0]  sync_ok;
    logic [L*8-1:0] rx_data;
    logic [L-1:0]  rx_ctl;
    logic [L*8-1:0] col_data;
    logic [L-1:0]  col_ctl;
    logic          col_valid;
    logic          lanes_aligned;
    logic          overflow_err;

    always #2.5 clk = ~clk;

    lane_deskew dut (
        .clk(clk), .rst_n(rst_n), .sync_ok(sync_ok), .rx_data(rx_data), .rx_ctl(rx_ctl),
        .col_data(col_data), .col_ctl(col_ctl), .col_valid(col_valid),
        .lanes_aligned(lanes_aligned), .overflow_err(overflow_err)
    );

    logic [8:0] strm [L][N];
    logic [8:0] base [N];
    int skew [L];
    int first_a [L];
    int period, shift_at, extra_from, sync_drop_at;
    bit expect_ovf;
    int n_chk = 0, n_fail = 0;
    bit m_lock; int m_acq, m_miss;
    int cols_seen, errs_seen, ever_locked;

    task automatic check(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [8:0] filler();
        logic [8:0] w;
        w = ($urandom % 8 == 0) ? 9'h1BC : {1'b0, 8'($urandom)};
        return w;
    endfunction

    function automatic logic [8:0] exp_word(int l, int idx);
        return (idx < N) ? strm[l][idx] : 9'h000;
    endfunction

    task automatic build();
        for (int c = 0; c < N; c++) base[c] = (c >= period && c % period == 0) ? AW9 : filler();
        for (int l = 0; l < L; l++) begin
            first_a[l] = N;
            for (int c = 0; c < N; c++) begin
                int src; int m; logic [8:0] w;
                src = c - skew[l];
                if (l == 0 && shift_at >= 0 && c >= shift_at) src--;
                w = (src >= 0) ? base[src] : filler();
                if (l == 0 && extra_from >= 0 && src >= extra_from) begin
                    m = src % period;
                    if (m == period/2 - 1 || m == period/2 || m == period/2 + 1) w = AW9;
                end
                strm[l][c] = w;
                if (w == AW9 && first_a[l] == N) first_a[l] = c;
            end
        end
    endtask

    // status model, one column at a time (R5 R6 R7 R8 R9 R10)
    task automatic model_step(bit valid, bit sync_all);
        int na;
        na = 0;
        for (int l = 0; l < L; l++) if ({col_ctl[l], col_data[l*8 +: 8]} == AW9) na++;
        if (!sync_all) begin
            m_lock = 0; m_acq = 0; m_miss = 0;
        end else if (valid) begin
            if (!m_lock) begin
                if (na == L) begin
                    if (m_acq == 3) begin m_lock = 1; m_acq = 0; m_miss = 0; end
                    else m_acq++;
                end else if (na > 0) m_acq = 0;
            end else begin
                if (na == L) m_miss = 0;
                else if (na > 0) begin
                    if (m_miss == 3) begin m_lock = 0; m_miss = 0; end
                    else m_miss++;
                end
            end
        end
    endtask

    task automatic do_reset();
        rst_n = 0; sync_ok = '1; rx_data = '0; rx_ctl = '0;
        repeat (3) @(negedge clk);
        check(col_valid == 0 && lanes_aligned == 0 && overflow_err == 0 &&
              col_data == '0 && col_ctl == '0, "R11 reset outputs",
              {col_valid, lanes_aligned, overflow_err}, 0);
        rst_n = 1;
        m_lock = 0; m_acq = 0; m_miss = 0;
    endtask

    task automatic run();
        int k;
        build();
        k = 0; cols_seen = 0; errs_seen = 0; ever_locked = 0;
        for (int cyc = 0; cyc < N + TAIL; cyc++) begin
            @(negedge clk);
            check(lanes_aligned == m_lock, "R5,R6,R7,R8,R9,R10 status", lanes_aligned, m_lock);
            if (lanes_aligned) ever_locked = 1;
            if (overflow_err) errs_seen++;
            if (col_valid) begin
                cols_seen++;
                if (!expect_ovf) begin
                    for (int l = 0; l < L; l++) begin
                        logic [8:0] e;
                        e = exp_word(l, first_a[l] + k);
                        check({col_ctl[l], col_data[l*8 +: 8]} == e, "R1,R2 column word",
                              {col_ctl[l], col_data[l*8 +: 8]}, e);
                    end
                end
                k++;
            end
            sync_ok = (cyc == sync_drop_at) ? 4'b1011 : 4'b1111;
            for (int l = 0; l < L; l++) begin
                logic [8:0] w;
                w = (cyc < N) ? strm[l][cyc] : 9'h000;
                rx_ctl[l] = w[8];
                rx_data[l*8 +: 8] = w[7:0];
            end
            model_step(col_valid, &sync_ok);
        end
    endtask

    task automatic setup(int s0, int s1, int s2, int s3, int p);
        skew[0] = s0; skew[1] = s1; skew[2] = s2; skew[3] = s3;
        period = p; shift_at = -1; extra_from = -1; sync_drop_at = -1; expect_ovf = 0;
    endtask

    bit done = 0;

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20250611));
        rst_n = 0; sync_ok = '1; rx_data = '0; rx_ctl = '0;
        do_reset();

        // skew right up to the queue limit
        setup(0, 3, 7, 15, 20); run();
        check(errs_seen == 0, "R3 no error at skew 15", errs_seen, 0);
        check(cols_seen > 0, "R2 output started", cols_seen, 1);
        check(lanes_aligned == 1, "R5 lock acquired", lanes_aligned, 1);
        // reset in the middle of a locked stream
        do_reset();

        for (int i = 0; i < 3; i++) begin
            setup($urandom % 16, $urandom % 16, $urandom % 16, $urandom % 16, 8 + $urandom % 17);
            run();
            check(errs_seen == 0, "R3 random skew no error", errs_seen, 0);
            check(lanes_aligned == 1, "R5 random lock", lanes_aligned, 1);
            do_reset();
        end

        // lane 0 slips one word after lock
        setup(2, 0, 5, 1, 16); shift_at = 150; run();
        check(ever_locked == 1, "R5 locked before slip", ever_locked, 1);
        check(lanes_aligned == 0, "R7 lock lost after slip", lanes_aligned, 0);
        do_reset();

        // stray /A/ bursts from the start: count keeps restarting
        setup(1, 4, 0, 2, 16); extra_from = 16; run();
        check(ever_locked == 0, "R6 never locks", ever_locked, 0);
        do_reset();

        // stray /A/ bursts after lock: three misses, then a hit
        setup(1, 4, 0, 2, 16); extra_from = 130; run();
        check(lanes_aligned == 1, "R8 lock held", lanes_aligned, 1);
        do_reset();

        // one-cycle sync loss on lane 2
        setup(0, 6, 3, 9, 16); sync_drop_at = 150; run();
        check(lanes_aligned == 1, "R10 relocked", lanes_aligned, 1);
        do_reset();

        // skew 16 overflows
        setup(0, 0, 0, 16, 20); expect_ovf = 1; run();
        check(errs_seen > 0, "R4 error pulse", errs_seen, 1);
        check(cols_seen == 0, "R4 no column output", cols_seen, 0);
        do_reset();

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule